// File: doc/BRIEF.md
# Time-Shared Trunk Switch

This block moves data from one of several sources to one of several destinations over a single shared trunk. A source multiplexer places the chosen source word on the trunk. The trunk then feeds the enable side of a destination decoder, so the decoder works as a demultiplexer: only the addressed destination sees the trunk value, and every other destination stays at zero.

A small slot sequencer shares the trunk over time. It holds a table of (source, destination) pairs that is filled through a write port. Each pulse on `slot_tick` starts a new slot, latches the next table entry into the datapath selects, and advances the pointer. After the entry at `last_idx` the pointer returns to entry 0.

The word width is a parameter, and every bit lane uses the same selects. With `WIDTH` = 1 the block is a single-line switch. With a wider `WIDTH` and two sources it is the parallel bus form. A global enable gates the whole path.

Top module: `trunk_switch`

## Requirements
- R1: After a synchronous reset (`rst` high, active high), every destination output is 0 until the first `slot_tick` has been taken, whatever `en` and `src_data` are. Reset also returns the slot pointer to entry 0.
- R2: During an active slot with `en` = 1, destination word d equals source word s, where (s, d) is the pair latched at the slot start. Source word s is `src_data[s*WIDTH +: WIDTH]`, destination word d is `dst_data[d*WIDTH +: WIDTH]`, and the output follows `src_data` combinationally within the slot.
- R3: Every destination that is not the latched one outputs all zeros.
- R4: While `en` = 0, all destination outputs are 0.
- R5: Each `slot_tick` latches the table entry at the pointer and advances the pointer. Entries are used in order 0, 1, and so on up to `last_idx`, then the pointer wraps to 0. After reset the first tick uses entry 0.
- R6: The applied selects change only on a `slot_tick` cycle. A table write during a slot, including a write to the entry currently in use, leaves the routing of that slot unchanged. The new value is used the next time that entry is loaded.
- R7: All `WIDTH` bit lanes of a word are routed with the same selects.
- R8: A table entry with source select 1 and destination select 5 connects the second source to the sixth destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global path enable |
| src_data | input | N_SRC*WIDTH | Source words, word s at bits s*WIDTH |
| slot_tick | input | 1 | Starts the next slot |
| last_idx | input | $clog2(DEPTH) | Index of the last valid table entry |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(DEPTH) | Table entry to write |
| wr_src | input | $clog2(N_SRC) | Source select to store |
| wr_dst | input | $clog2(N_DST) | Destination select to store |
| dst_data | output | N_DST*WIDTH | Destination words, word d at bits d*WIDTH |

## Verification
The assertions assume that `N_SRC` and `N_DST` are powers of two, so every select value addresses a real source or destination. The random stimulus only draws select values inside those ranges. The stimulus never sets `wr_en` and `slot_tick` in the same cycle. The bench can therefore model a table write and a slot change as separate events. `last_idx` is sometimes changed while the pointer already lies beyond it, which checks wrap-around through the natural overflow of the pointer.

// File: rtl/trunk_switch.sv
module trunk_switch #(
  parameter int N_SRC = 4,
  parameter int N_DST = 8,
  parameter int WIDTH = 1,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [N_SRC*WIDTH-1:0]     src_data,
  input  logic                       slot_tick,
  input  logic [$clog2(DEPTH)-1:0]   last_idx,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx,
  input  logic [$clog2(N_SRC)-1:0]   wr_src,
  input  logic [$clog2(N_DST)-1:0]   wr_dst,
  output logic [N_DST*WIDTH-1:0]     dst_data
);
  localparam int SW = $clog2(N_SRC);
  localparam int DW = $clog2(N_DST);
  localparam int IW = $clog2(DEPTH);

  logic [SW-1:0]    tbl_src [DEPTH];
  logic [DW-1:0]    tbl_dst [DEPTH];
  logic [IW-1:0]    ptr;
  logic [SW-1:0]    cur_src;
  logic [DW-1:0]    cur_dst;
  logic             live;
  logic [WIDTH-1:0] src_w [N_SRC];
  logic [WIDTH-1:0] trunk;
  logic [N_DST-1:0] dec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl_src[i] <= '0;
        tbl_dst[i] <= '0;
      end
    end else if (wr_en) begin
      tbl_src[wr_idx] <= wr_src;
      tbl_dst[wr_idx] <= wr_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      live    <= 1'b0;
    end else if (slot_tick) begin
      cur_src <= tbl_src[ptr];
      cur_dst <= tbl_dst[ptr];
      live    <= 1'b1;
      ptr     <= (ptr == last_idx) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_w[s] = src_data[s*WIDTH +: WIDTH];
  end

  assign trunk = src_w[cur_src];

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    assign dec_en[d] = live && en && (cur_dst == DW'(d));
    assign dst_data[d*WIDTH +: WIDTH] = dec_en[d] ? trunk : '0;
  end
endmodule

// File: rtl/trunk_switch_chk.sv
module trunk_switch_chk #(
  parameter int N_SRC = 4,
  parameter int N_DST = 8,
  parameter int WIDTH = 1,
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic                     slot_tick,
  input logic [$clog2(DEPTH)-1:0] last_idx,
  input logic [N_SRC*WIDTH-1:0]   src_data,
  input logic [N_DST*WIDTH-1:0]   dst_data,
  input logic [$clog2(DEPTH)-1:0] ptr,
  input logic [$clog2(N_SRC)-1:0] cur_src,
  input logic [$clog2(N_DST)-1:0] cur_dst,
  input logic                     live
);
  logic [WIDTH-1:0] sw [N_SRC];
  logic [WIDTH-1:0] dw [N_DST];
  logic [N_DST-1:0] busy;

  for (genvar s = 0; s < N_SRC; s++) begin : g_s
    assign sw[s] = src_data[s*WIDTH +: WIDTH];
  end
  for (genvar d = 0; d < N_DST; d++) begin : g_d
    assign dw[d]   = dst_data[d*WIDTH +: WIDTH];
    assign busy[d] = |dw[d];
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dst_data == '0 && ptr == '0));
  a_r2_route: assert property (@(posedge clk) disable iff (rst)
    (live && en) |-> (dw[cur_dst] == sw[cur_src]));
  a_r3_single_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy));
  a_r4_gated: assert property (@(posedge clk) disable iff (rst)
    !en |-> (dst_data == '0));
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && ptr == last_idx) |=> (ptr == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> ($stable(cur_src) && $stable(cur_dst) && $stable(ptr)));
endmodule

bind trunk_switch trunk_switch_chk #(
  .N_SRC(N_SRC), .N_DST(N_DST), .WIDTH(WIDTH), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .slot_tick(slot_tick), .last_idx(last_idx),
  .src_data(src_data), .dst_data(dst_data), .ptr(ptr),
  .cur_src(cur_src), .cur_dst(cur_dst), .live(live)
);

// File: tb/test_trunk_switch.sv
module test_trunk_switch;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 4, N_DST = 8, WIDTH = 4, DEPTH = 8;
  localparam int SW = $clog2(N_SRC), DW = $clog2(N_DST), IW = $clog2(DEPTH);

  logic clk = 0, rst = 1, en = 0, slot_tick = 0, wr_en = 0;
  logic [N_SRC*WIDTH-1:0] src_data = '0;
  logic [IW-1:0] last_idx = '0, wr_idx = '0;
  logic [SW-1:0] wr_src = '0;
  logic [DW-1:0] wr_dst = '0;
  logic [N_DST*WIDTH-1:0] dst_data;

  int errors = 0, checks = 0;
  logic [SW-1:0] m_tsrc [DEPTH];
  logic [DW-1:0] m_tdst [DEPTH];
  logic [IW-1:0] m_ptr = '0;
  logic [SW-1:0] m_src = '0;
  logic [DW-1:0] m_dst = '0;
  logic m_live = 0;

  trunk_switch #(.N_SRC(N_SRC), .N_DST(N_DST), .WIDTH(WIDTH), .DEPTH(DEPTH)) i_trunk_switch (
    .clk(clk), .rst(rst), .en(en), .src_data(src_data), .slot_tick(slot_tick),
    .last_idx(last_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(wr_src),
    .wr_dst(wr_dst), .dst_data(dst_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N_DST*WIDTH-1:0] expect_out();
    logic [N_DST*WIDTH-1:0] r = '0;
    if (m_live && en)
      r[int'(m_dst)*WIDTH +: WIDTH] = src_data[int'(m_src)*WIDTH +: WIDTH];
    return r;
  endfunction

  task automatic check(string tag);
    logic [N_DST*WIDTH-1:0] e;
    #1;
    e = expect_out();
    checks++;
    if (dst_data !== e) begin
      errors++;
      $display("FAIL %s: dst_data=%h expected=%h", tag, dst_data, e);
    end
  endtask

  task automatic write_entry(int idx, int s, int d);
    wr_en = 1; wr_idx = IW'(idx); wr_src = SW'(s); wr_dst = DW'(d);
    @(posedge clk); #1;
    wr_en = 0;
    m_tsrc[idx] = SW'(s); m_tdst[idx] = DW'(d);
  endtask

  task automatic tick();
    slot_tick = 1;
    @(posedge clk); #1;
    slot_tick = 0;
    m_src = m_tsrc[m_ptr]; m_dst = m_tdst[m_ptr]; m_live = 1;
    m_ptr = (m_ptr == last_idx) ? '0 : m_ptr + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin m_tsrc[i] = '0; m_tdst[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    en = 1; src_data = '1;
    check("R1 reset quiet");
    repeat (2) @(posedge clk);
    src_data = 16'hBEEF;
    check("R1 quiet before first slot");

    // R8: source 1 to destination 5
    write_entry(0, 1, 5);
    last_idx = '0;
    tick();
    src_data = 16'h00A0;
    check("R8 Y to E");
    // R7: every lane follows the same selects
    src_data = 16'h0050;
    check("R7 lanes");
    // R4
    en = 0;
    check("R4 disabled");
    en = 1;
    // R6: rewrite the entry in use mid-slot
    write_entry(0, 3, 2);
    src_data = 16'h7C30;
    check("R6 mid-slot write ignored");
    tick();
    check("R6 new value used at next load");

    // R5: ordered walk and wrap
    for (int i = 0; i < 4; i++) write_entry(i, i, 7 - i);
    last_idx = 3;
    for (int i = 0; i < 9; i++) begin
      tick();
      src_data = 16'h1234 + 16'(i * 16'h1111);
      check("R5 order and wrap");
    end

    // random mix: R2 R3
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 2) write_entry(int'($urandom_range(0, DEPTH-1)), int'($urandom_range(0, N_SRC-1)),
                             int'($urandom_range(0, N_DST-1)));
      else if (r < 6) tick();
      else if (r == 6) last_idx = IW'($urandom_range(0, DEPTH-1));
      else @(posedge clk);
      #1;
      src_data = N_SRC*WIDTH'($urandom);
      en = ($urandom_range(0, 7) != 0);
      if (!en) check("R4 random");
      else check("R2 R3 random");
    end

    // R1: reset again mid-slot
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    m_live = 0; m_ptr = '0;
    for (int i = 0; i < DEPTH; i++) begin m_tsrc[i] = '0; m_tdst[i] = '0; end
    check("R1 reset clears route");
    tick();
    check("R1 first slot after reset uses entry 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule